// File: doc/BRIEF.md
# Power Controller Register Front End

This block is the register-facing side of a power management controller. Software uses a simple read/write bus to set up which power domains go up or down. It sets a domain mask for software power-up, a domain mask for software power-down, and a domain mask for hardware-driven changes. It also sets, for each of eight external wake/sleep event lines, whether that event powers domains up, powers them down, or is ignored. A software request does nothing on its own. It is launched only when three key bytes reach a commit register in the correct order. The power-up key and the power-down key are different byte strings.

Requests from software and from event lines go to a domain sequencer. The sequencer sits outside this block, behind a start pulse, a direction bit and a domain mask. While the sequencer reports busy, each request waits in a slot of its own and is sent once the sequencer is free. Completion and failure reports from the sequencer, hardware-request notices and key errors are gathered in a write-one-to-clear interrupt status register. An enable register picks which status bits can raise the interrupt line.

Top module: `pwr_regfront`

## Requirements
- R1: After reset, every writable register and both status registers read zero, and `irq` and `seq_start` are low.
- R2: Writes take effect at the clock edge. A read returns its data on `bus_rdata` one cycle after `bus_rd`. The map is: 0x04 event power-up enables (8 bits), 0x08 event power-down enables (8 bits), 0x0C software power-up domain mask (8 bits), 0x10 software power-down domain mask (8 bits), 0x48 interrupt enables (9 bits), 0x5C hardware domain mask (8 bits), 0x80 the `cur_mode` input, 0x88 event status, 0x8C interrupt status. Bit 2 of both event enable registers always reads 0. Unmapped addresses read 0.
- R3: Writing the low bytes 0xFF, 0x05, 0x50 in order to the commit register at 0x44 issues one `seq_start` with `seq_dir`=1 and `seq_mask` equal to the software power-up mask. No start is issued if that mask is zero.
- R4: Writing the low bytes 0xFF, 0x0A, 0xA0 in order to 0x44 issues one `seq_start` with `seq_dir`=0 and `seq_mask` equal to the software power-down mask.
- R5: A write to 0x44 that breaks the expected order returns the key checker to its start state and issues no start. The break sets interrupt status bit 3 if it comes after the power-down second byte 0x0A, and sets bit 2 in every other case. A correct sequence after a break works normally.
- R6: An event line i (i ≠ 2) that is high while its power-up or power-down enable is set sets event status bit i and interrupt status bit 1. It requests the domains in the hardware domain mask, with `seq_dir`=1 if any such event has its power-up enable set and 0 otherwise. No start is issued when the hardware domain mask is zero. Event line 2 never has any effect.
- R7: An event line whose two enable bits are both clear changes no status bit and issues no start.
- R8: No `seq_start` is issued in the cycle after a cycle with `seq_busy` high, nor in the cycle after a start. Requests that arrive while the sequencer is busy wait, and a waiting software request goes out before a waiting hardware one.
- R9: Writing ones to 0x88 or 0x8C clears those status bits. A bit that is set by its source in the same cycle as the clear stays set.
- R10: `irq` is registered and follows the OR of the interrupt status bits ANDed with the interrupt enables, one cycle later.
- R11: `seq_done` sets interrupt status bit 0, `seq_hw_fail[1:0]` sets bits 5:4, and `seq_ch_fail[2:0]` sets bits 8:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| hw_evt | input | NEVT | Wake/sleep event lines, one request per high cycle |
| cur_mode | input | NDOM | Current domain power state, readable at 0x80 |
| seq_busy | input | 1 | Sequencer is working on a request |
| seq_done | input | 1 | Sequencer finished a request |
| seq_hw_fail | input | 2 | Sequencer hardware-request failure flags |
| seq_ch_fail | input | 3 | Power-channel failure flags |
| seq_start | output | 1 | One-cycle request pulse to the sequencer |
| seq_dir | output | 1 | Request direction, 1 = power up |
| seq_mask | output | NDOM | Domains of the request |
| irq | output | 1 | Interrupt line |

## Verification
Two pairs of functions can act on the same status bit in the same cycle. The first pair is a software write-one-to-clear and a new status event. The bench raises `seq_done` in the same cycle as a write of 1 to bit 0 of the interrupt status, reads back to confirm the bit is still set, and then clears it with a write on its own. The second pair is a software commit and an event request arriving while the sequencer is busy. The bench loads both slots behind a held `seq_busy`, confirms that no start escapes, then releases the sequencer and checks that the software mask comes out before the hardware one.

// File: rtl/pwr_rf_pkg.sv
package pwr_rf_pkg;

  localparam logic [7:0] ADR_EVT_UP   = 8'h04;
  localparam logic [7:0] ADR_EVT_DN   = 8'h08;
  localparam logic [7:0] ADR_SW_UP    = 8'h0C;
  localparam logic [7:0] ADR_SW_DN    = 8'h10;
  localparam logic [7:0] ADR_KEY      = 8'h44;
  localparam logic [7:0] ADR_INT_EN   = 8'h48;
  localparam logic [7:0] ADR_HW_DOM   = 8'h5C;
  localparam logic [7:0] ADR_CUR      = 8'h80;
  localparam logic [7:0] ADR_EVT_STAT = 8'h88;
  localparam logic [7:0] ADR_INT_STAT = 8'h8C;

  localparam logic [7:0] KEY_ARM  = 8'hFF;
  localparam logic [7:0] KEY_UP1  = 8'h05;
  localparam logic [7:0] KEY_UP2  = 8'h50;
  localparam logic [7:0] KEY_DN1  = 8'h0A;
  localparam logic [7:0] KEY_DN2  = 8'hA0;

  localparam int INT_W      = 9;
  localparam int IB_DONE    = 0;
  localparam int IB_HWREQ   = 1;
  localparam int IB_KEY_A   = 2;
  localparam int IB_KEY_B   = 3;

  typedef enum logic [1:0] {
    KS_IDLE,
    KS_ARMED,
    KS_UP_HALF,
    KS_DN_HALF
  } key_state_e;

endpackage

// File: rtl/pwr_rf_keychk.sv
module pwr_rf_keychk
  import pwr_rf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  output logic       commit_up,
  output logic       commit_dn,
  output logic       bad_a,
  output logic       bad_b,
  output key_state_e state_o
);

  key_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= KS_IDLE;
      commit_up <= 1'b0;
      commit_dn <= 1'b0;
      bad_a     <= 1'b0;
      bad_b     <= 1'b0;
    end else begin
      commit_up <= 1'b0;
      commit_dn <= 1'b0;
      bad_a     <= 1'b0;
      bad_b     <= 1'b0;
      if (key_wr) begin
        unique case (state_q)
          KS_IDLE: begin
            if (key_byte == KEY_ARM) state_q <= KS_ARMED;
            else                     bad_a   <= 1'b1;
          end
          KS_ARMED: begin
            if (key_byte == KEY_UP1)      state_q <= KS_UP_HALF;
            else if (key_byte == KEY_DN1) state_q <= KS_DN_HALF;
            else begin
              state_q <= KS_IDLE;
              bad_a   <= 1'b1;
            end
          end
          KS_UP_HALF: begin
            state_q <= KS_IDLE;
            if (key_byte == KEY_UP2) commit_up <= 1'b1;
            else                     bad_a     <= 1'b1;
          end
          KS_DN_HALF: begin
            state_q <= KS_IDLE;
            if (key_byte == KEY_DN2) commit_dn <= 1'b1;
            else                     bad_b     <= 1'b1;
          end
          default: state_q <= KS_IDLE;
        endcase
      end
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/pwr_rf_route.sv
module pwr_rf_route #(
  parameter int NDOM     = 8,
  parameter int NEVT     = 8,
  parameter int RSVD_EVT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NEVT-1:0] hw_evt,
  input  logic [NEVT-1:0] up_en,
  input  logic [NEVT-1:0] dn_en,
  input  logic [NDOM-1:0] dom_mask,
  output logic [NEVT-1:0] acc_q,
  output logic            req_vld_q,
  output logic            req_dir_q,
  output logic [NDOM-1:0] req_mask_q
);

  logic [NEVT-1:0] qual;
  logic [NEVT-1:0] acc;
  logic [NEVT-1:0] up_hit;

  for (genvar g = 0; g < NEVT; g++) begin : g_evt
    if (g == RSVD_EVT) begin : g_rsvd
      assign qual[g] = 1'b0;
    end else begin : g_live
      assign qual[g] = hw_evt[g];
    end
    assign acc[g]    = qual[g] & (up_en[g] | dn_en[g]);
    assign up_hit[g] = qual[g] & up_en[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q      <= '0;
      req_vld_q  <= 1'b0;
      req_dir_q  <= 1'b0;
      req_mask_q <= '0;
    end else begin
      acc_q      <= acc;
      req_vld_q  <= (|acc) && (|dom_mask);
      req_dir_q  <= |up_hit;
      req_mask_q <= dom_mask;
    end
  end

endmodule

// File: rtl/pwr_rf_issue.sv
module pwr_rf_issue #(
  parameter int NDOM = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sw_vld,
  input  logic            sw_dir,
  input  logic [NDOM-1:0] sw_mask,
  input  logic            hw_vld,
  input  logic            hw_dir,
  input  logic [NDOM-1:0] hw_mask,
  input  logic            seq_busy,
  output logic            seq_start,
  output logic            seq_dir,
  output logic [NDOM-1:0] seq_mask
);

  logic            sw_p, hw_p;
  logic            sw_pd, hw_pd;
  logic [NDOM-1:0] sw_pm, hw_pm;
  logic            free;

  assign free = !seq_busy && !seq_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_p      <= 1'b0;
      sw_pd     <= 1'b0;
      sw_pm     <= '0;
      hw_p      <= 1'b0;
      hw_pd     <= 1'b0;
      hw_pm     <= '0;
      seq_start <= 1'b0;
      seq_dir   <= 1'b0;
      seq_mask  <= '0;
    end else begin
      seq_start <= 1'b0;
      if (free && sw_p) begin
        seq_start <= 1'b1;
        seq_dir   <= sw_pd;
        seq_mask  <= sw_pm;
        sw_p      <= 1'b0;
      end else if (free && hw_p) begin
        seq_start <= 1'b1;
        seq_dir   <= hw_pd;
        seq_mask  <= hw_pm;
        hw_p      <= 1'b0;
      end
      if (sw_vld) begin
        sw_p  <= 1'b1;
        sw_pd <= sw_dir;
        sw_pm <= sw_mask;
      end
      if (hw_vld) begin
        hw_p  <= 1'b1;
        hw_pd <= hw_dir;
        hw_pm <= hw_mask;
      end
    end
  end

endmodule

// File: rtl/pwr_rf_status.sv
module pwr_rf_status
  import pwr_rf_pkg::*;
#(
  parameter int NEVT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INT_W-1:0] int_set,
  input  logic [INT_W-1:0] int_clr,
  input  logic [NEVT-1:0]  evt_set,
  input  logic [NEVT-1:0]  evt_clr,
  input  logic [INT_W-1:0] int_en,
  output logic [INT_W-1:0] int_stat,
  output logic [NEVT-1:0]  evt_stat,
  output logic             irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      int_stat <= '0;
      evt_stat <= '0;
      irq      <= 1'b0;
    end else begin
      int_stat <= (int_stat & ~int_clr) | int_set;
      evt_stat <= (evt_stat & ~evt_clr) | evt_set;
      irq      <= |(int_stat & int_en);
    end
  end

endmodule

// File: rtl/pwr_regfront.sv
module pwr_regfront
  import pwr_rf_pkg::*;
#(
  parameter int NDOM     = 8,
  parameter int NEVT     = 8,
  parameter int RSVD_EVT = 2,
  parameter int AW       = 8,
  parameter int DW       = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NEVT-1:0] hw_evt,
  input  logic [NDOM-1:0] cur_mode,
  input  logic            seq_busy,
  input  logic            seq_done,
  input  logic [1:0]      seq_hw_fail,
  input  logic [2:0]      seq_ch_fail,
  output logic            seq_start,
  output logic            seq_dir,
  output logic [NDOM-1:0] seq_mask,
  output logic            irq
);

  localparam logic [NEVT-1:0] RSVD_MASK = NEVT'(1) << RSVD_EVT;

  logic [NEVT-1:0]  evt_up_q, evt_dn_q;
  logic [NDOM-1:0]  sw_up_q, sw_dn_q, hw_dom_q;
  logic [INT_W-1:0] int_en_q;

  logic sel_evt_up, sel_evt_dn, sel_sw_up, sel_sw_dn, sel_key;
  logic sel_int_en, sel_hw_dom, sel_cur, sel_evt_st, sel_int_st;

  assign sel_evt_up = bus_addr == AW'(ADR_EVT_UP);
  assign sel_evt_dn = bus_addr == AW'(ADR_EVT_DN);
  assign sel_sw_up  = bus_addr == AW'(ADR_SW_UP);
  assign sel_sw_dn  = bus_addr == AW'(ADR_SW_DN);
  assign sel_key    = bus_addr == AW'(ADR_KEY);
  assign sel_int_en = bus_addr == AW'(ADR_INT_EN);
  assign sel_hw_dom = bus_addr == AW'(ADR_HW_DOM);
  assign sel_cur    = bus_addr == AW'(ADR_CUR);
  assign sel_evt_st = bus_addr == AW'(ADR_EVT_STAT);
  assign sel_int_st = bus_addr == AW'(ADR_INT_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_up_q <= '0;
      evt_dn_q <= '0;
      sw_up_q  <= '0;
      sw_dn_q  <= '0;
      hw_dom_q <= '0;
      int_en_q <= '0;
    end else if (bus_wr) begin
      if (sel_evt_up) evt_up_q <= bus_wdata[NEVT-1:0] & ~RSVD_MASK;
      if (sel_evt_dn) evt_dn_q <= bus_wdata[NEVT-1:0] & ~RSVD_MASK;
      if (sel_sw_up)  sw_up_q  <= bus_wdata[NDOM-1:0];
      if (sel_sw_dn)  sw_dn_q  <= bus_wdata[NDOM-1:0];
      if (sel_hw_dom) hw_dom_q <= bus_wdata[NDOM-1:0];
      if (sel_int_en) int_en_q <= bus_wdata[INT_W-1:0];
    end
  end

  key_state_e key_state;
  logic       commit_up, commit_dn, bad_a, bad_b;

  pwr_rf_keychk u_key (
    .clk       (clk),
    .rst       (rst),
    .key_wr    (bus_wr && sel_key),
    .key_byte  (bus_wdata[7:0]),
    .commit_up (commit_up),
    .commit_dn (commit_dn),
    .bad_a     (bad_a),
    .bad_b     (bad_b),
    .state_o   (key_state)
  );

  logic [NEVT-1:0] evt_acc;
  logic            hw_vld, hw_dir;
  logic [NDOM-1:0] hw_mask;

  pwr_rf_route #(
    .NDOM     (NDOM),
    .NEVT     (NEVT),
    .RSVD_EVT (RSVD_EVT)
  ) u_route (
    .clk        (clk),
    .rst        (rst),
    .hw_evt     (hw_evt),
    .up_en      (evt_up_q),
    .dn_en      (evt_dn_q),
    .dom_mask   (hw_dom_q),
    .acc_q      (evt_acc),
    .req_vld_q  (hw_vld),
    .req_dir_q  (hw_dir),
    .req_mask_q (hw_mask)
  );

  logic            sw_vld;
  logic [NDOM-1:0] sw_mask;

  assign sw_mask = commit_up ? sw_up_q : sw_dn_q;
  assign sw_vld  = (commit_up && (|sw_up_q)) || (commit_dn && (|sw_dn_q));

  pwr_rf_issue #(
    .NDOM (NDOM)
  ) u_issue (
    .clk       (clk),
    .rst       (rst),
    .sw_vld    (sw_vld),
    .sw_dir    (commit_up),
    .sw_mask   (sw_mask),
    .hw_vld    (hw_vld),
    .hw_dir    (hw_dir),
    .hw_mask   (hw_mask),
    .seq_busy  (seq_busy),
    .seq_start (seq_start),
    .seq_dir   (seq_dir),
    .seq_mask  (seq_mask)
  );

  logic [INT_W-1:0] int_set, int_clr, int_stat;
  logic [NEVT-1:0]  evt_clr, evt_stat;

  assign int_set = {seq_ch_fail, seq_hw_fail, bad_b, bad_a, |evt_acc, seq_done};
  assign int_clr = (bus_wr && sel_int_st) ? bus_wdata[INT_W-1:0] : '0;
  assign evt_clr = (bus_wr && sel_evt_st) ? bus_wdata[NEVT-1:0]  : '0;

  pwr_rf_status #(
    .NEVT (NEVT)
  ) u_stat (
    .clk      (clk),
    .rst      (rst),
    .int_set  (int_set),
    .int_clr  (int_clr),
    .evt_set  (evt_acc),
    .evt_clr  (evt_clr),
    .int_en   (int_en_q),
    .int_stat (int_stat),
    .evt_stat (evt_stat),
    .irq      (irq)
  );

  logic [DW-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (sel_evt_up)      rd_d[NEVT-1:0]  = evt_up_q;
    else if (sel_evt_dn) rd_d[NEVT-1:0]  = evt_dn_q;
    else if (sel_sw_up)  rd_d[NDOM-1:0]  = sw_up_q;
    else if (sel_sw_dn)  rd_d[NDOM-1:0]  = sw_dn_q;
    else if (sel_hw_dom) rd_d[NDOM-1:0]  = hw_dom_q;
    else if (sel_int_en) rd_d[INT_W-1:0] = int_en_q;
    else if (sel_cur)    rd_d[NDOM-1:0]  = cur_mode;
    else if (sel_evt_st) rd_d[NEVT-1:0]  = evt_stat;
    else if (sel_int_st) rd_d[INT_W-1:0] = int_stat;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_d;
  end

endmodule

// File: rtl/pwr_rf_chk.sv
module pwr_rf_chk
  import pwr_rf_pkg::*;
#(
  parameter int NDOM     = 8,
  parameter int NEVT     = 8,
  parameter int RSVD_EVT = 2,
  parameter int AW       = 8,
  parameter int DW       = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic             seq_busy,
  input logic             seq_start,
  input logic [NDOM-1:0]  seq_mask,
  input logic             irq,
  input key_state_e       key_state,
  input logic [INT_W-1:0] int_stat,
  input logic [NEVT-1:0]  evt_stat,
  input logic [INT_W-1:0] int_en_q
);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    seq_busy |=> !seq_start);

  // R8
  start_gap_chk: assert property (@(posedge clk) disable iff (rst)
    seq_start |=> !seq_start);

  // R3
  start_mask_chk: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> (seq_mask != '0));

  // R5
  key_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(ADR_KEY) && key_state == KS_IDLE
     && bus_wdata[7:0] != KEY_ARM) |=> ##1 int_stat[IB_KEY_A]);

  // R6
  rsvd_evt_chk: assert property (@(posedge clk) disable iff (rst)
    !evt_stat[RSVD_EVT]);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(int_en_q) == '0) |-> !irq);

endmodule

bind pwr_regfront pwr_rf_chk #(
  .NDOM     (NDOM),
  .NEVT     (NEVT),
  .RSVD_EVT (RSVD_EVT),
  .AW       (AW),
  .DW       (DW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .seq_busy  (seq_busy),
  .seq_start (seq_start),
  .seq_mask  (seq_mask),
  .irq       (irq),
  .key_state (key_state),
  .int_stat  (int_stat),
  .evt_stat  (evt_stat),
  .int_en_q  (int_en_q)
);

// File: tb/tb_pwr_regfront.sv
module tb_pwr_regfront;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  hw_evt, cur_mode;
  logic        seq_busy, seq_done;
  logic [1:0]  seq_hw_fail;
  logic [2:0]  seq_ch_fail;
  logic        seq_start, seq_dir, irq;
  logic [7:0]  seq_mask;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwr_regfront dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_evt(hw_evt), .cur_mode(cur_mode), .seq_busy(seq_busy),
    .seq_done(seq_done), .seq_hw_fail(seq_hw_fail), .seq_ch_fail(seq_ch_fail),
    .seq_start(seq_start), .seq_dir(seq_dir), .seq_mask(seq_mask), .irq(irq)
  );

  // address, write data, expected read-back
  localparam int NV = 8;
  localparam logic [71:0] VEC [0:NV-1] = '{
    {8'h04, 32'h0000_00FF, 32'h0000_00FB},
    {8'h08, 32'h0000_000F, 32'h0000_000B},
    {8'h0C, 32'h0000_01A5, 32'h0000_00A5},
    {8'h10, 32'h0000_003C, 32'h0000_003C},
    {8'h5C, 32'h0000_01FF, 32'h0000_00FF},
    {8'h48, 32'h0000_FFFF, 32'h0000_01FF},
    {8'h60, 32'h0000_0123, 32'h0000_0000},
    {8'h48, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic key(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    wr(8'h44, {24'h0, b0});
    wr(8'h44, {24'h0, b1});
    wr(8'h44, {24'h0, b2});
  endtask

  task automatic wait_start(input int lim, output logic found, output logic [7:0] m, output logic d);
    found = 1'b0; m = '0; d = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (seq_start) begin
        found = 1'b1; m = seq_mask; d = seq_dir;
        break;
      end
    end
  endtask

  task automatic pulse_evt(input logic [7:0] e);
    @(negedge clk);
    hw_evt = e;
    @(negedge clk);
    hw_evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic        f, d;
    logic [7:0]  m;

    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    hw_evt = 0; cur_mode = 8'h5A; seq_busy = 0; seq_done = 0;
    seq_hw_fail = 0; seq_ch_fail = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 start", {31'h0, seq_start}, 32'h0);
    rd(8'h04, r); check("R1 evt_up", r, 0);
    rd(8'h0C, r); check("R1 sw_up", r, 0);
    rd(8'h48, r); check("R1 int_en", r, 0);
    rd(8'h5C, r); check("R1 hw_dom", r, 0);
    rd(8'h88, r); check("R1 evt_stat", r, 0);
    rd(8'h8C, r); check("R1 int_stat", r, 0);

    // R2 register table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], r);
      check("R2 readback", r, VEC[i][31:0]);
    end
    rd(8'h80, r); check("R2 cur_mode", r, 32'h5A);

    // R3 power-up key
    key(8'hFF, 8'h05, 8'h50);
    wait_start(10, f, m, d);
    check("R3 start", {31'h0, f}, 1);
    check("R3 mask", {24'h0, m}, 32'hA5);
    check("R3 dir", {31'h0, d}, 1);

    // R4 power-down key
    key(8'hFF, 8'h0A, 8'hA0);
    wait_start(10, f, m, d);
    check("R4 start", {31'h0, f}, 1);
    check("R4 mask", {24'h0, m}, 32'h3C);
    check("R4 dir", {31'h0, d}, 0);

    // R5 broken key from idle
    wr(8'h8C, 32'h1FF);
    wr(8'h44, 32'h05);
    wait_start(6, f, m, d);
    check("R5 no start idle", {31'h0, f}, 0);
    rd(8'h8C, r); check("R5 bit2", r & 32'hC, 32'h4);
    // R9 plain clear
    wr(8'h8C, 32'h1FF);
    rd(8'h8C, r); check("R9 cleared", r, 0);
    // R5 broken in power-down path
    key(8'hFF, 8'h0A, 8'h55);
    wait_start(6, f, m, d);
    check("R5 no start dn", {31'h0, f}, 0);
    rd(8'h8C, r); check("R5 bit3", r & 32'hC, 32'h8);
    wr(8'h8C, 32'h1FF);
    // R5 repeated arm byte breaks, then recovery
    key(8'hFF, 8'hFF, 8'h05);
    rd(8'h8C, r); check("R5 bit2 arm", r & 32'hC, 32'h4);
    key(8'hFF, 8'h05, 8'h50);
    wait_start(10, f, m, d);
    check("R5 recovery", {31'h0, f}, 1);
    wr(8'h8C, 32'h1FF);

    // R3 empty mask issues nothing
    wr(8'h0C, 32'h0);
    key(8'hFF, 8'h05, 8'h50);
    wait_start(8, f, m, d);
    check("R3 empty mask", {31'h0, f}, 0);

    // R6 event routing
    wr(8'h5C, 32'h30);
    wr(8'h04, 32'h01);
    wr(8'h08, 32'h02);
    pulse_evt(8'h01);
    wait_start(10, f, m, d);
    check("R6 up start", {31'h0, f}, 1);
    check("R6 up mask", {24'h0, m}, 32'h30);
    check("R6 up dir", {31'h0, d}, 1);
    rd(8'h88, r); check("R6 evt stat", r, 32'h01);
    rd(8'h8C, r); check("R6 hwreq bit1", r & 32'h2, 32'h2);
    pulse_evt(8'h02);
    wait_start(10, f, m, d);
    check("R6 dn dir", {31'h0, d}, 0);
    check("R6 dn start", {31'h0, f}, 1);
    wr(8'h04, 32'h08);
    wr(8'h08, 32'h08);
    pulse_evt(8'h08);
    wait_start(10, f, m, d);
    check("R6 both up wins", {30'h0, f, d}, 32'h3);
    wr(8'h88, 32'hFF);
    wr(8'h8C, 32'h1FF);
    wr(8'h04, 32'hFF);
    pulse_evt(8'h04);
    wait_start(8, f, m, d);
    check("R6 event2 no start", {31'h0, f}, 0);
    rd(8'h88, r); check("R6 event2 no status", r, 0);

    // R7 disabled event
    wr(8'h04, 32'h01);
    wr(8'h08, 32'h00);
    pulse_evt(8'h20);
    wait_start(8, f, m, d);
    check("R7 no start", {31'h0, f}, 0);
    rd(8'h88, r); check("R7 evt stat", r, 0);
    rd(8'h8C, r); check("R7 int stat", r, 0);

    // R8 both slots held while busy, software first
    wr(8'h0C, 32'h03);
    seq_busy = 1'b1;
    pulse_evt(8'h01);
    key(8'hFF, 8'h05, 8'h50);
    wait_start(10, f, m, d);
    check("R8 held", {31'h0, f}, 0);
    @(negedge clk); seq_busy = 1'b0;
    wait_start(10, f, m, d);
    check("R8 sw first", {23'h0, f, m}, {23'h0, 1'b1, 8'h03});
    wait_start(10, f, m, d);
    check("R8 hw second", {23'h0, f, m}, {23'h0, 1'b1, 8'h30});
    wr(8'h88, 32'hFF);
    wr(8'h8C, 32'h1FF);

    // R9 set wins over same-cycle clear
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h8C; bus_wdata = 32'h1; seq_done = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; seq_done = 1'b0;
    rd(8'h8C, r); check("R9 set wins", r, 32'h1);
    wr(8'h8C, 32'h1);
    rd(8'h8C, r); check("R9 then clear", r, 0);

    // R11 failure sources
    @(negedge clk); seq_hw_fail = 2'b10; seq_ch_fail = 3'b001;
    @(negedge clk); seq_hw_fail = 0; seq_ch_fail = 0;
    rd(8'h8C, r); check("R11 fail bits", r, 32'h060);

    // R10 irq gating
    repeat (3) @(negedge clk);
    check("R10 masked", {31'h0, irq}, 0);
    wr(8'h48, 32'h20);
    repeat (2) @(negedge clk);
    check("R10 enabled", {31'h0, irq}, 1);
    wr(8'h8C, 32'h20);
    repeat (2) @(negedge clk);
    check("R10 cleared", {31'h0, irq}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule